// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block is the digital sequencing core of a processor power supervisor. Its inputs are comparator flags that are already digital and synchronous to the block clock: the supply is below the reset threshold, the supply is below the backup battery, and the power-fail sense input is below its reference. From these flags it drives a stretched reset in both polarities, a low-line flag, a power-fail flag, a battery-switchover flag and a gated chip-enable for backed-up memory.

A watchdog timer runs from the same clock. Software services it by toggling a service pin, and either edge counts. When the timer expires it issues a full reset pulse of the same stretched length that a supply dip produces. The first timeout window after any reset is always the long window. After a service, the window follows the period-select input. All time constants are parameters in clock ticks.

Top module: `supply_supervisor`

## Requirements
- R1: While either below-threshold or below-battery is high at a clock edge, the reset is active (reset_lo_o = 0) after that edge.
- R2: After the last edge at which the supply is bad, the reset stays active for exactly HOLD_TICKS further clock edges and is released at the HOLD_TICKS-th edge. The same applies after the synchronous reset rst_n is released.
- R3: reset_hi_o is always the exact complement of reset_lo_o.
- R4: When the watchdog is enabled and its window expires with no service edge, the reset goes active at that edge and is held for exactly HOLD_TICKS edges. This repeats for every expired window.
- R5: The first window after any reset (supply, watchdog or rst_n) lasts LONG_TICKS edges, whatever value wd_short_i has.
- R6: After a service edge, the next window lasts SHORT_TICKS edges when wd_short_i = 1 and LONG_TICKS edges when wd_short_i = 0. The window is counted from the edge that samples the toggled service pin.
- R7: A rising or a falling edge on wdi_i clears the watchdog count. Servicing more often than the window keeps the reset released.
- R8: With wd_en_i = 0 the watchdog never asserts reset.
- R9: ce_n_o equals ce_n_i while below-threshold is low. It is 1 (memory deselected) while below-threshold is high.
- R10: lowline_n_o is 0 exactly when below-threshold or below-battery is high. It is combinational, so recovery is immediate.
- R11: pfail_n_o equals the inverse of pf_below_i, except that it is forced to 0 while below-battery is high.
- R12: batt_on_o equals below_batt_i. A value of 1 means the output rail is fed from the battery.
- R13: While rst_n is low, reset_lo_o = 0 and reset_hi_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| below_thr_i | input | 1 | Supply below the reset threshold |
| below_batt_i | input | 1 | Supply below the backup battery |
| pf_below_i | input | 1 | Power-fail sense below its reference |
| wdi_i | input | 1 | Watchdog service pin, either edge services |
| wd_en_i | input | 1 | Watchdog enable |
| wd_short_i | input | 1 | 1 selects the short window after a service |
| ce_n_i | input | 1 | Active-low chip enable from the address decoder |
| reset_lo_o | output | 1 | Active-low reset |
| reset_hi_o | output | 1 | Active-high reset |
| lowline_n_o | output | 1 | Low when the supply is bad |
| pfail_n_o | output | 1 | Low on power fail or on battery |
| batt_on_o | output | 1 | High when the rail is on battery |
| ce_n_o | output | 1 | Gated active-low chip enable |

## Verification
Random combinations of the three supply flags and the chip-enable input check every gated output against a bench model. This separates the threshold-only gating of the chip enable from the battery-only forcing of the power-fail flag. Directed sequences then measure the stretch length after a power-on reset, after a supply dip and after a watchdog bite. Unserviced runs with the short window selected show that the long window follows every reset. A single service followed by silence shows the short window, or the long window when deselected. Frequent servicing on alternating edges, and a disabled watchdog, show that no reset fires.

// File: rtl/sup_pkg.sv
// Shared types and helpers for the supply supervisor.
// Assumes: all counters run from zero to a positive tick count minus one.
package sup_pkg;

    // Comparator flags, already synchronous to the block clock.
    typedef struct packed {
        logic below_thr;
        logic below_batt;
        logic pf_below;
    } sup_flags_t;

    // Watchdog window selection after a service edge.
    typedef enum logic {
        PER_LONG  = 1'b0,
        PER_SHORT = 1'b1
    } wd_per_e;

    // Bits needed to count 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sup_reset_gen.sv
// Reset stretcher: holds reset active while the supply is bad or a watchdog
// bite arrives. It then keeps reset active for HOLD_TICKS more edges.
// Assumes: supply_bad and wd_bite are synchronous to clk; HOLD_TICKS >= 1.
module sup_reset_gen
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_bad,
    input  logic wd_bite,
    output logic rst_act
);

    localparam int unsigned HW = cnt_width(HOLD_TICKS);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    logic [HW-1:0] hold_cnt;

    // Hold counter: restart on any cause, count down the stretch after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_act  <= 1'b1;
            hold_cnt <= '0;
        end else if (supply_bad || wd_bite) begin
            rst_act  <= 1'b1;
            hold_cnt <= '0;
        end else if (rst_act) begin
            if (hold_cnt == HOLD_LAST) begin
                rst_act  <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // A bad supply at an edge leaves reset active after it.
    p_bad_forces_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        supply_bad |=> rst_act);

    // Reset is never released before the stretch count is used up.
    p_hold_not_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_act && hold_cnt != HOLD_LAST) |=> rst_act);

    // A watchdog bite starts a fresh full-length stretch.
    p_bite_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_bite |=> (rst_act && hold_cnt == '0));

endmodule

// File: rtl/sup_watchdog.sv
// Watchdog timer: counts edges with no service toggle and raises a bite on
// the edge at which the window expires. The window after any reset is long.
// After a service edge the window follows the period select.
// Assumes: wdi is synchronous to clk; LONG_TICKS, SHORT_TICKS >= 1.
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 16000,
    parameter int unsigned SHORT_TICKS = 1000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rst_act,
    input  logic    wd_en,
    input  wd_per_e wd_sel,
    input  logic    wdi,
    output logic    bite
);

    localparam int unsigned MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned CW = cnt_width(MAX_TICKS);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] MAX_LAST   = CW'(MAX_TICKS - 1);

    logic          wdi_q;
    logic          kick;
    logic          use_long;
    logic [CW-1:0] wcnt;
    logic [CW-1:0] win_last;

    // Either edge of the service pin counts as a service.
    always_comb kick = wdi ^ wdi_q;

    // Window end: long after a reset, otherwise per the select input.
    always_comb win_last = (use_long || wd_sel == PER_LONG) ? LONG_LAST : SHORT_LAST;

    // Bite when the window is used up and no service arrives this edge.
    always_comb bite = wd_en && !rst_act && !kick && (wcnt >= win_last);

    // Delay the service pin by one edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wdi_q <= 1'b0;
        else        wdi_q <= wdi;
    end

    // Window counter and long-window flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt     <= '0;
            use_long <= 1'b1;
        end else if (rst_act || !wd_en) begin
            wcnt     <= '0;
            use_long <= 1'b1;
        end else if (kick) begin
            wcnt     <= '0;
            use_long <= 1'b0;
        end else if (bite) begin
            wcnt     <= '0;
        end else begin
            wcnt     <= wcnt + 1'b1;
        end
    end

    // A service edge clears the count and ends the long-window phase.
    p_kick_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && wd_en && !rst_act) |=> (wcnt == '0 && !use_long));

    // Every reset re-arms the long window.
    p_long_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |=> use_long);

    // A disabled watchdog holds its count at zero.
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> (wcnt == '0));

    // The count never passes the longest window.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= MAX_LAST);

endmodule

// File: rtl/sup_out_gate.sv
// Output gating: turns the comparator flags into the low-line, power-fail,
// battery-on and gated chip-enable outputs, and the combined bad-supply term.
// Assumes: flags are valid every cycle; purely combinational.
module sup_out_gate
    import sup_pkg::*;
(
    input  sup_flags_t flags,
    input  logic       ce_n_in,
    output logic       supply_bad,
    output logic       lowline_n,
    output logic       pfail_n,
    output logic       batt_on,
    output logic       ce_n_out
);

    // Supply is bad below the threshold or below the battery.
    always_comb supply_bad = flags.below_thr | flags.below_batt;

    // Flag outputs; power fail is forced on while running from the battery.
    always_comb begin
        lowline_n = ~supply_bad;
        batt_on   = flags.below_batt;
        pfail_n   = ~(flags.pf_below | flags.below_batt);
    end

    // Chip enable is blocked (driven high) below the reset threshold.
    always_comb ce_n_out = flags.below_thr ? 1'b1 : ce_n_in;

endmodule

// File: rtl/supply_supervisor.sv
// Supply supervisor top: joins output gating, reset stretcher and watchdog.
// Assumes: all inputs synchronous to clk; WD_PRESENT = 0 removes the timer.
module supply_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_TICKS  = 2000,
    parameter int unsigned LONG_TICKS  = 16000,
    parameter int unsigned SHORT_TICKS = 1000,
    parameter bit          WD_PRESENT  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_thr_i,
    input  logic below_batt_i,
    input  logic pf_below_i,
    input  logic wdi_i,
    input  logic wd_en_i,
    input  logic wd_short_i,
    input  logic ce_n_i,
    output logic reset_lo_o,
    output logic reset_hi_o,
    output logic lowline_n_o,
    output logic pfail_n_o,
    output logic batt_on_o,
    output logic ce_n_o
);

    sup_flags_t flags;
    logic       supply_bad;
    logic       rst_act;
    logic       wd_bite;

    // Gather the comparator flags.
    always_comb flags = '{below_thr: below_thr_i, below_batt: below_batt_i, pf_below: pf_below_i};

    sup_out_gate u_gate (
        .flags      (flags),
        .ce_n_in    (ce_n_i),
        .supply_bad (supply_bad),
        .lowline_n  (lowline_n_o),
        .pfail_n    (pfail_n_o),
        .batt_on    (batt_on_o),
        .ce_n_out   (ce_n_o)
    );

    sup_reset_gen #(.HOLD_TICKS(HOLD_TICKS)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_bad (supply_bad),
        .wd_bite    (wd_bite),
        .rst_act    (rst_act)
    );

    generate
        if (WD_PRESENT) begin : g_wd
            sup_watchdog #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_wd (
                .clk     (clk),
                .rst_n   (rst_n),
                .rst_act (rst_act),
                .wd_en   (wd_en_i),
                .wd_sel  (wd_per_e'(wd_short_i)),
                .wdi     (wdi_i),
                .bite    (wd_bite)
            );
        end else begin : g_no_wd
            assign wd_bite = 1'b0;
        end
    endgenerate

    // Both reset polarities come from the one stretcher state.
    always_comb begin
        reset_hi_o = rst_act;
        reset_lo_o = ~rst_act;
    end

    // The chip enable is blocked whenever the supply is below threshold.
    p_ce_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        below_thr_i |-> ce_n_o);

    // While running from the battery the power-fail flag is low.
    p_pfail_on_batt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        below_batt_i |-> !pfail_n_o);

    // Reset held active through the synchronous reset.
    p_rst_hold_r13: assert property (@(posedge clk)
        !rst_n |=> !reset_lo_o);

endmodule

// File: tb/sim_supply_supervisor.sv
// Bench for supply_supervisor: random flag patterns plus directed timing runs.
module sim_supply_supervisor;

    localparam int unsigned HOLD  = 12;
    localparam int unsigned LONGP = 60;
    localparam int unsigned SHRT  = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic below_thr = 1'b0, below_batt = 1'b0, pf_below = 1'b0;
    logic wdi = 1'b0, wd_en = 1'b0, wd_short = 1'b0, ce_n = 1'b1;
    logic reset_lo, reset_hi, lowline_n, pfail_n, batt_on, ce_n_out;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    supply_supervisor #(.HOLD_TICKS(HOLD), .LONG_TICKS(LONGP), .SHORT_TICKS(SHRT)) u0 (
        .clk(clk), .rst_n(rst_n), .below_thr_i(below_thr), .below_batt_i(below_batt),
        .pf_below_i(pf_below), .wdi_i(wdi), .wd_en_i(wd_en), .wd_short_i(wd_short),
        .ce_n_i(ce_n), .reset_lo_o(reset_lo), .reset_hi_o(reset_hi),
        .lowline_n_o(lowline_n), .pfail_n_o(pfail_n), .batt_on_o(batt_on), .ce_n_o(ce_n_out)
    );

    // Bench models of the gated outputs.
    function automatic logic exp_ce(input logic thr, input logic ce);
        return thr ? 1'b1 : ce;
    endfunction
    function automatic logic exp_lowline(input logic thr, input logic batt);
        return !(thr || batt);
    endfunction
    function automatic logic exp_pfail(input logic pf, input logic batt);
        return batt ? 1'b0 : !pf;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_gates(input string tag);
        check({tag, " R9 ce"}, ce_n_out, exp_ce(below_thr, ce_n));
        check({tag, " R10 lowline"}, lowline_n, exp_lowline(below_thr, below_batt));
        check({tag, " R11 pfail"}, pfail_n, exp_pfail(pf_below, below_batt));
        check({tag, " R12 batt_on"}, batt_on, below_batt);
        check({tag, " R3 complement"}, reset_hi, !reset_lo);
    endtask

    // Expect reset held for HOLD edges then released.
    task automatic check_stretch(input string req);
        step(HOLD - 1);
        check({req, " still held"}, reset_lo, 0);
        step(1);
        check({req, " released"}, reset_lo, 1);
    endtask

    // Expect the watchdog to bite after exactly n edges.
    task automatic check_window(input string req, input int n);
        step(n - 1);
        check({req, " before window end"}, reset_lo, 1);
        step(1);
        check({req, " bite at window end"}, reset_lo, 0);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic prev_bad;
        int lows;
        void'($urandom(32'd4242));

        // R13: reset state
        step(3);
        check("R13 reset_lo during rst_n", reset_lo, 0);
        check("R13 reset_hi during rst_n", reset_hi, 1);

        // R2: stretch after rst_n release
        rst_n = 1'b1;
        check_stretch("R2 power-on");

        // Random flag patterns, watchdog off
        prev_bad = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (prev_bad) check("R1 reset after bad supply", reset_lo, 0);
            check("R3 complement", reset_hi, !reset_lo);
            below_thr  = ($urandom % 4) == 0;
            below_batt = ($urandom % 5) == 0;
            pf_below   = $urandom % 2;
            ce_n       = $urandom % 2;
            #1;
            check_gates("random");
            prev_bad = below_thr | below_batt;
        end
        @(negedge clk);
        below_thr = 1'b0; below_batt = 1'b0; pf_below = 1'b0; ce_n = 1'b0;
        step(HOLD + 1);
        check("R2 released after random", reset_lo, 1);

        // R8: watchdog disabled, no service, no reset
        lows = 0;
        for (int i = 0; i < 3 * LONGP; i++) begin
            step(1);
            if (!reset_lo) lows++;
        end
        check("R8 no bite while disabled", lows, 0);

        // R5/R4: enable with short selected, unserviced; long window twice
        wd_short = 1'b1;
        wd_en = 1'b1;
        check_window("R5 first window long", LONGP);
        check_stretch("R4 bite pulse length");
        check_window("R5 long after watchdog reset", LONGP);
        check_stretch("R4 second bite pulse");

        // R6: one service then silence gives the short window
        wdi = ~wdi;
        check_window("R6 short window", SHRT + 1);
        check_stretch("R4 pulse after short bite");

        // R7: frequent service on alternating edges keeps reset released
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            wdi = ~wdi;
            for (int k = 0; k < 20; k++) begin
                step(1);
                if (!reset_lo) lows++;
            end
        end
        check("R7 serviced both edges no bite", lows, 0);

        // R6: long selected after a service
        wd_short = 1'b0;
        wdi = ~wdi;
        check_window("R6 long window selected", LONGP + 1);
        check_stretch("R4 pulse after long bite");

        // R1/R11/R12: on battery while watchdog runs
        wd_short = 1'b1;
        below_batt = 1'b1;
        #1;
        check_gates("battery");
        check("R11 pfail forced low", pfail_n, 0);
        check("R10 lowline on battery", lowline_n, 0);
        step(1);
        check("R1 reset on battery", reset_lo, 0);
        lows = 0;
        for (int i = 0; i < 2 * LONGP; i++) begin
            step(1);
            if (!reset_lo) lows++;
        end
        check("R1 held through battery period", lows, 2 * LONGP);
        below_batt = 1'b0;
        #1;
        check("R10 lowline recovers at once", lowline_n, 1);
        check_stretch("R2 after supply recovery");
        check_window("R5 long after supply reset", LONGP);

        // R9: threshold blocks chip enable, battery alone does not
        step(HOLD);
        ce_n = 1'b0;
        below_thr = 1'b1;
        #1;
        check("R9 ce blocked below threshold", ce_n_out, 1);
        below_thr = 1'b0;
        below_batt = 1'b1;
        #1;
        check("R9 ce passes on battery only", ce_n_out, 0);
        below_batt = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule